// File: doc/BRIEF.md
# External Memory Bus Master Controller

This block turns single read and write requests from a processor core into cycles on an external memory bus. Each request is accepted only while the controller is idle. The request carries a full address, a direction, a conditional flag with its condition result, and a width choice between a 32-bit word and a 16-bit short word. The controller then runs three phases. The first is a one-cycle address and select setup. The second is a strobe phase, which a slow device can stretch with wait states. The third is a one-cycle hold, during which the result is handed back to the core.

The two most significant address bits choose one of four active-low bank selects. The remaining bits go out as the bus address. An early write indicator goes low with the address on every write, so a write whose condition fails is begun and then abandoned without a write strobe. A device extends an access by pulling the acknowledge line low. A suspend input releases the bus one cycle later through the output-enable signals, and parks any access in flight. That access is replayed from setup once suspend drops.

Top module: `ext_bus_master`

## Requirements
- R1: During setup, strobe and hold, exactly one bit of `bank_sel_n` is low, namely bit `req_addr[25:24]`, and `bus_addr` equals `req_addr[23:0]`. In idle and while stalled, `bank_sel_n` is 4'b1111.
- R2: For a conditional request (`req_cond`=1) whose `req_cond_ok` is 0, the bank select is still asserted for three cycles, but neither `rd_n` nor `wr_n` goes low and memory is left unchanged.
- R3: For every write, including a failed conditional write, `sw_n` is low in the setup cycle and the strobe phase. For a read it stays high. `wr_n` is never low without `sw_n` low.
- R4: An access lasts one setup cycle, N+1 strobe cycles and one hold cycle. `rsp_done` is high only during the hold cycle, and `req_ready` is low from setup until the end of hold.
- R5: Each cycle in which `bus_ack_low` is 1 during a strobe adds one strobe cycle, with the address held stable. A value of 0 means acknowledge is high, and the access then proceeds.
- R6: Read data on `bus_rdata` is captured at the edge that ends the strobe phase and appears on `rsp_rdata` during the single-cycle `rsp_done` pulse.
- R7: When `req_short` is 1, a write drives `bus_wdata[31:16]` to zero and a read returns `bus_rdata[15:0]` zero-extended.
- R8: One cycle after `suspend` is sampled high, `addr_oe` and `data_oe` are 0. `data_oe` is high only during a write access.
- R9: While `suspend` is high, an access does not complete. After release, it restarts from setup with its original address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_addr | input | 26 | Full request address, top two bits pick the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cond | input | 1 | Request comes from a conditional instruction |
| req_cond_ok | input | 1 | Condition result (used when req_cond=1) |
| req_short | input | 1 | 1 = 16-bit short word, 0 = 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Captured read data |
| bus_addr | output | 24 | External address |
| bus_wdata | output | 32 | External write data |
| bus_rdata | input | 32 | External read data |
| bank_sel_n | output | 4 | Active-low bank selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| sw_n | output | 1 | Active-low early write indicator |
| bus_ack_low | input | 1 | 1 when a device holds acknowledge low |
| suspend | input | 1 | Bus suspend request |
| addr_oe | output | 1 | Enable for address, select and strobe pads |
| data_oe | output | 1 | Enable for data pads |

## Verification
The hardest case to reach is a suspend that lands in the middle of a stretched strobe. From the ports it must look like an access that has been stalled and then replayed, not one that finished twice or lost its data. The bench holds a read in its strobe phase with several acknowledge-low cycles and raises suspend while the read strobe is seen low. It checks that the pads float and that no completion appears while suspend is high, then drops suspend. After release, it verifies through the scoreboard that the single completion returns the right data at the original address. A second case raises suspend before a write is issued, and a later read-back confirms that the write landed exactly once.

// File: rtl/ext_bus_master.sv
module ext_bus_master #(
  parameter int BW = 24,
  parameter int DW = 32,
  localparam int AW = BW + 2,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_cond,
  input  logic          req_cond_ok,
  input  logic          req_short,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [BW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [3:0]    bank_sel_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          sw_n,
  input  logic          bus_ack_low,
  input  logic          suspend,
  output logic          addr_oe,
  output logic          data_oe
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_STALL} state_t;

  state_t        st;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q, rdata_q;
  logic          wr_q, short_q, go_q, susp_q;

  wire active = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  wire strobe = (st == S_STROBE) && go_q;
  wire finish = !go_q || !bus_ack_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      d_q     <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      short_q <= 1'b0;
      go_q    <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      susp_q <= suspend;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q     <= req_addr;
          d_q     <= req_wdata;
          wr_q    <= req_write;
          short_q <= req_short;
          go_q    <= !req_cond || req_cond_ok;
          st      <= S_SETUP;
        end
        S_SETUP: st <= suspend ? S_STALL : S_STROBE;
        S_STROBE: begin
          if (suspend) st <= S_STALL;
          else if (finish) begin
            st <= S_HOLD;
            if (go_q && !wr_q)
              rdata_q <= short_q ? {{(DW-HW){1'b0}}, bus_rdata[HW-1:0]} : bus_rdata;
          end
        end
        S_HOLD:  st <= S_IDLE;
        S_STALL: if (!suspend) st <= S_SETUP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_done   = (st == S_HOLD);
  assign rsp_rdata  = rdata_q;
  assign bus_addr   = a_q[BW-1:0];
  assign bus_wdata  = short_q ? {{(DW-HW){1'b0}}, d_q[HW-1:0]} : d_q;
  assign bank_sel_n = ~(4'(active) << a_q[AW-1:AW-2]);
  assign rd_n       = !(strobe && !wr_q);
  assign wr_n       = !(strobe && wr_q);
  assign sw_n       = !(wr_q && ((st == S_SETUP) || (st == S_STROBE)));
  assign addr_oe    = !susp_q;
  assign data_oe    = !susp_q && wr_q && active;

endmodule

// File: rtl/ext_bus_master_chk.sv
module ext_bus_master_chk #(
  parameter int BW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          suspend,
  input logic          bus_ack_low,
  input logic          rd_n,
  input logic          wr_n,
  input logic          sw_n,
  input logic [3:0]    bank_sel_n,
  input logic [BW-1:0] bus_addr,
  input logic          addr_oe,
  input logic          data_oe,
  input logic          rsp_done,
  input logic          req_ready
);

  // R1
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~bank_sel_n));

  // R1
  strobe_has_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (bank_sel_n != 4'hF));

  // R3
  write_early_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> !sw_n);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && bus_ack_low && !suspend) |=> (!rd_n && $stable(bus_addr)));

  // R8
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (!addr_oe && !data_oe));

endmodule

bind ext_bus_master ext_bus_master_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .bus_ack_low(bus_ack_low),
  .rd_n(rd_n), .wr_n(wr_n), .sw_n(sw_n), .bank_sel_n(bank_sel_n),
  .bus_addr(bus_addr), .addr_oe(addr_oe), .data_oe(data_oe),
  .rsp_done(rsp_done), .req_ready(req_ready)
);

// File: tb/tb_ext_bus_master.sv
`timescale 1ns/1ps
module tb_ext_bus_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cond = 1'b0, req_cond_ok = 1'b0, req_short = 1'b0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0, bus_rdata, rsp_rdata, bus_wdata;
  logic        req_ready, rsp_done, rd_n, wr_n, sw_n, addr_oe, data_oe;
  logic        bus_ack_low = 1'b0, suspend = 1'b0;
  logic [23:0] bus_addr;
  logic [3:0]  bank_sel_n;

  always #5 clk = ~clk;

  ext_bus_master dut (.*);

  typedef struct {
    logic        chk_data;
    logic [31:0] data;
    logic [3:0]  bank;
    logic [23:0] addr;
    int          strobes;
    int          bank_cyc;
    logic        is_wr;
    logic        short_w;
    logic        chk_len;
  } item_t;

  item_t       q[$];
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  int          wait_left = 0;
  int          checks = 0, errors = 0;
  int          strobe_cnt = 0, bank_cnt = 0, cycles = 0;
  logic        sw_seen = 1'b0;

  assign bus_rdata = mem[bus_addr[3:0]];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk)
    if (!wr_n && !bus_ack_low) mem[bus_addr[3:0]] <= bus_wdata;

  always @(negedge clk) begin
    if ((!rd_n || !wr_n) && wait_left > 0) begin
      bus_ack_low <= 1'b1;
      wait_left   <= wait_left - 1;
    end else bus_ack_low <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rd_n || !wr_n) strobe_cnt++;
      if (bank_sel_n != 4'hF) bank_cnt++;
      if (!sw_n) sw_seen = 1'b1;
      if (!wr_n && q.size() > 0) begin
        if (q[0].short_w) chk(bus_wdata[31:16] == 16'h0, "R7 short write upper bits", {16'h0, bus_wdata[31:16]}, 32'h0);
        chk(data_oe == 1'b1, "R8 data_oe during write", {31'h0, data_oe}, 32'h1);
      end
      if (rsp_done) begin
        if (q.size() == 0) chk(1'b0, "R4 unexpected done", 32'h1, 32'h0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(bank_sel_n == it.bank, "R1 bank select", {28'h0, bank_sel_n}, {28'h0, it.bank});
          chk(bus_addr == it.addr, "R1 bus address", {8'h0, bus_addr}, {8'h0, it.addr});
          chk(rd_n && wr_n && !req_ready, "R4 hold phase", {30'h0, rd_n, wr_n}, 32'h3);
          chk(sw_seen == it.is_wr, "R3 early write indicator", {31'h0, sw_seen}, {31'h0, it.is_wr});
          if (it.chk_data) chk(rsp_rdata == it.data, "R6 read data", rsp_rdata, it.data);
          if (it.chk_len) begin
            chk(strobe_cnt == it.strobes, "R5 strobe length", strobe_cnt, it.strobes);
            chk(bank_cnt == it.bank_cyc, "R4 access length", bank_cnt, it.bank_cyc);
          end
        end
        strobe_cnt = 0; bank_cnt = 0; sw_seen = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      report();
    end
  end

  task automatic issue(input logic [25:0] a, input logic w, input logic c, input logic ok,
                       input logic s, input logic [31:0] d, input int waits, input logic len);
    item_t it;
    logic go;
    go = !c || ok;
    while (!req_ready) @(negedge clk);
    it.chk_data = go && !w;
    it.data     = s ? {16'h0, exp_mem[a[3:0]][15:0]} : exp_mem[a[3:0]];
    it.bank     = ~(4'b0001 << a[25:24]);
    it.addr     = a[23:0];
    it.strobes  = go ? waits + 1 : 0;
    it.bank_cyc = go ? waits + 4 - 1 : 3;
    it.is_wr    = w;
    it.short_w  = s && w;
    it.chk_len  = len;
    if (go && w) exp_mem[a[3:0]] = s ? {16'h0, d[15:0]} : d;
    q.push_back(it);
    req_addr = a; req_write = w; req_cond = c; req_cond_ok = ok; req_short = s; req_wdata = d;
    wait_left = waits;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 32'hA5C30000 + i * 32'h00010101;
      exp_mem[i] = 32'hA5C30000 + i * 32'h00010101;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bank_sel_n == 4'hF, "R1 reset selects idle", {28'h0, bank_sel_n}, 32'hF);
    chk(rd_n && wr_n && sw_n && req_ready && addr_oe && !rsp_done, "R4 reset outputs",
        {26'h0, rd_n, wr_n, sw_n, req_ready, addr_oe, rsp_done}, 32'h3E);

    issue(26'h0000003, 0, 0, 0, 0, 32'h0, 0, 1);            drain();
    issue(26'h1000005, 1, 0, 0, 0, 32'hDEADBEEF, 2, 1);     drain();
    issue(26'h1000005, 0, 0, 0, 0, 32'h0, 1, 1);            drain();
    // R2 failed conditional write, then read back unchanged
    issue(26'h2000006, 1, 1, 0, 0, 32'h11112222, 0, 1);     drain();
    issue(26'h2000006, 0, 0, 0, 0, 32'h0, 0, 1);            drain();
    // R2 failed conditional read
    issue(26'h3000007, 0, 1, 0, 0, 32'h0, 0, 1);            drain();
    issue(26'h3000007, 1, 1, 1, 0, 32'h12345678, 0, 1);     drain();
    issue(26'h3000007, 0, 0, 0, 0, 32'h0, 3, 1);            drain();
    // R7 short write then word read, and short read
    issue(26'h0000008, 1, 0, 0, 1, 32'hCAFE1234, 1, 1);     drain();
    issue(26'h0000008, 0, 0, 0, 0, 32'h0, 0, 1);            drain();
    issue(26'h1000009, 0, 0, 0, 1, 32'h0, 0, 1);            drain();

    // R8 R9 suspend during a stretched read strobe
    issue(26'h200000A, 0, 0, 0, 0, 32'h0, 4, 0);
    while (rd_n) @(negedge clk);
    suspend = 1'b1;
    @(negedge clk);
    chk(!addr_oe && !data_oe, "R8 pads float after suspend", {30'h0, addr_oe, data_oe}, 32'h0);
    chk(bank_sel_n == 4'hF && rd_n, "R9 access parked", {27'h0, bank_sel_n, rd_n}, 32'h1F);
    repeat (3) begin
      @(negedge clk);
      chk(!rsp_done && rd_n, "R9 no completion while suspended", {30'h0, rsp_done, rd_n}, 32'h1);
    end
    suspend = 1'b0;
    @(negedge clk);
    chk(addr_oe == 1'b1, "R8 pads driven after release", {31'h0, addr_oe}, 32'h1);
    drain();

    // R9 suspend raised before a write is issued
    suspend = 1'b1;
    issue(26'h100000B, 1, 0, 0, 0, 32'h0BADF00D, 0, 0);
    repeat (4) begin
      @(negedge clk);
      chk(wr_n && !rsp_done, "R9 write held while suspended", {30'h0, wr_n, rsp_done}, 32'h2);
    end
    suspend = 1'b0;
    drain();
    issue(26'h100000B, 0, 0, 0, 0, 32'h0, 0, 1);            drain();

    report();
  end
endmodule